// File: doc/BRIEF.md
# Serial Receiver with Valid/Ready Output

This block turns an asynchronous serial line into a parallel word stream. The line rests high. A frame is one low start bit, then DATA_WIDTH data bits with the least significant bit first, then one high stop bit. Each good word appears on a valid/ready output register. It stays there until the consumer takes it.

Bit timing comes from the `baud_div` input. The value is the clock rate divided by eight times the baud rate, so one bit lasts `baud_div * 8` clock cycles. The input is not registered inside the block. Software may change it between frames, but a change in the middle of a frame can corrupt that frame. The line passes through a two-flop synchroniser. A falling edge starts a frame, and every bit is sampled in the middle of its bit time.

Two kinds of word are dropped, and each is reported by a one-cycle strobe. A word that completes while the previous word is still unread raises the overrun strobe. A word whose stop bit reads low raises the framing strobe.

Top module: `serial_rx_stream`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid`, `busy`, `err_overrun` and `err_frame` are all low.
- R2: A frame's data bits are taken least significant bit first. The word is presented on `out_data`, with the first data bit on the line in bit 0.
- R3: One bit lasts `baud_div * 8` cycles. A `baud_div` of 0 behaves as 1. `out_valid` rises exactly 3 + 4·p + 8·p·(DATA_WIDTH+1) cycles after the clock edge at which the line falls, where p is the effective divider value.
- R4: `out_valid` rises only in the cycle in which `busy` falls at the end of a good frame. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R5: A word is transferred only in a cycle in which `out_valid` and `out_ready` are both high. After that cycle `out_valid` is low, unless a new word is loaded in the same cycle.
- R6: If a good frame completes while an unread word is held and `out_ready` is low, `err_overrun` is high for exactly one cycle. The new word is dropped and the held word is kept.
- R7: If the stop bit is sampled low, `err_frame` is high for exactly one cycle and no word is presented. The next good frame is received normally.
- R8: If the line is high again when the start bit is re-sampled half a bit time after the falling edge, the block returns to idle. No word is presented and no strobe is raised.
- R9: `busy` is high from the start detection until the stop bit is sampled. Both error strobes appear in the cycle in which `busy` falls.
- R10: If the held word is taken in the same cycle that a new good frame completes, the new word is loaded, `out_valid` stays high and no overrun is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_serial | input | 1 | Asynchronous serial line, high when idle |
| baud_div | input | PRESCALE_W | Clock cycles per eighth of a bit |
| out_data | output | DATA_WIDTH | Received word |
| out_valid | output | 1 | Word in `out_data` is available |
| out_ready | input | 1 | Consumer accepts the word |
| busy | output | 1 | A frame is being received |
| err_overrun | output | 1 | One-cycle strobe: new word dropped because the output was full |
| err_frame | output | 1 | One-cycle strobe: stop bit read low, word dropped |

## Verification
Two things can happen in the same cycle: the consumer takes the held word, and the next frame's stop bit is sampled. The bench provokes this by holding `out_ready` low, receiving one word, and sending a second frame. It raises `out_ready` for only the single cycle before the stop-sample edge, and it computes that cycle from the divider value and the start edge. The result is judged at the ports. The old word must be delivered once, the new word must be presented with `out_valid` still high, and `err_overrun` must stay silent. A separate run leaves `out_ready` low across the same edge and expects the overrun strobe instead.

// File: rtl/srx_pkg.sv
package srx_pkg;

    // Receiver sequencing states
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    // Clock ticks per bit are the divider times 2**TICK_SHIFT
    localparam int TICK_SHIFT = 3;

    // Outcome of a stop-bit sample
    typedef struct packed {
        logic done;     // stop bit sampled this cycle
        logic good;     // stop bit was high
    } stop_evt_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int   STAGES     = 2,
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= RESET_LEVEL;
                else     chain[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RESET_LEVEL;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/srx_bit_timer.sv
module srx_bit_timer #(
    parameter int CW = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - CW'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/srx_out_slot.sv
module srx_out_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] data,
    output logic         overrun
);

    logic take;
    logic room;

    assign take = valid & ready;
    assign room = ~valid | take;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            data    <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= push & ~room;
            if (push && room) begin
                valid <= 1'b1;
                data  <= push_data;
            end else if (take) begin
                valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/serial_rx_stream.sv
module serial_rx_stream
    import srx_pkg::*;
#(
    parameter int DATA_WIDTH = 8,
    parameter int PRESCALE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_serial,
    input  logic [PRESCALE_W-1:0] baud_div,
    output logic [DATA_WIDTH-1:0] out_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic                  busy,
    output logic                  err_overrun,
    output logic                  err_frame
);

    localparam int CW = PRESCALE_W + TICK_SHIFT;
    localparam int IW = idx_width(DATA_WIDTH);

    logic                  rx_s;
    logic                  rx_prev;
    logic                  fall;
    logic [PRESCALE_W-1:0] div_eff;
    logic [CW-1:0]         bit_len;
    logic [CW-1:0]         half_len;

    rx_state_t             state, state_n;
    logic [IW-1:0]         bit_idx, bit_idx_n;
    logic [DATA_WIDTH-1:0] shreg, shreg_n;
    logic                  t_load;
    logic [CW-1:0]         t_val;
    logic                  t_exp;
    stop_evt_t             stop_evt;
    logic                  frame_q;

    srx_sync #(.STAGES(2), .RESET_LEVEL(1'b1)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_serial),
        .dout (rx_s)
    );

    always_ff @(posedge clk) begin
        if (rst) rx_prev <= 1'b1;
        else     rx_prev <= rx_s;
    end

    assign fall     = rx_prev & ~rx_s;
    assign div_eff  = (baud_div == '0) ? PRESCALE_W'(1) : baud_div;
    assign bit_len  = {div_eff, {TICK_SHIFT{1'b0}}} - CW'(1);
    assign half_len = {1'b0, div_eff, {(TICK_SHIFT-1){1'b0}}} - CW'(1);

    srx_bit_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    always_comb begin
        state_n   = state;
        bit_idx_n = bit_idx;
        shreg_n   = shreg;
        t_load    = 1'b0;
        t_val     = bit_len;
        stop_evt  = '0;
        case (state)
            RX_IDLE: begin
                if (fall) begin
                    state_n = RX_START;
                    t_load  = 1'b1;
                    t_val   = half_len;
                end
            end
            RX_START: begin
                if (t_exp) begin
                    if (!rx_s) begin
                        state_n   = RX_DATA;
                        bit_idx_n = '0;
                        t_load    = 1'b1;
                    end else begin
                        state_n = RX_IDLE;
                    end
                end
            end
            RX_DATA: begin
                if (t_exp) begin
                    shreg_n = {rx_s, shreg[DATA_WIDTH-1:1]};
                    t_load  = 1'b1;
                    if (bit_idx == IW'(DATA_WIDTH - 1)) begin
                        state_n = RX_STOP;
                    end else begin
                        bit_idx_n = bit_idx + IW'(1);
                    end
                end
            end
            RX_STOP: begin
                if (t_exp) begin
                    state_n       = RX_IDLE;
                    stop_evt.done = 1'b1;
                    stop_evt.good = rx_s;
                end
            end
            default: state_n = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            bit_idx <= '0;
            shreg   <= '0;
            frame_q <= 1'b0;
        end else begin
            state   <= state_n;
            bit_idx <= bit_idx_n;
            shreg   <= shreg_n;
            frame_q <= stop_evt.done & ~stop_evt.good;
        end
    end

    srx_out_slot #(.W(DATA_WIDTH)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .push      (stop_evt.done & stop_evt.good),
        .push_data (shreg),
        .ready     (out_ready),
        .valid     (out_valid),
        .data      (out_data),
        .overrun   (err_overrun)
    );

    assign busy      = (state != RX_IDLE);
    assign err_frame = frame_q;

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] out_data,
    input logic         out_valid,
    input logic         out_ready,
    input logic         busy,
    input logic         err_overrun,
    input logic         err_frame
);

    // R4: a stalled word holds
    a_r4_stall_holds: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R4: a word appears only as a frame ends
    a_r4_rise_at_end: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $fell(busy));

    // R5: valid drops only after a handshake
    a_r5_drop_after_take: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> $past(out_ready));

    // R6: overrun strobe lasts one cycle
    a_r6_overrun_single: assert property (@(posedge clk) disable iff (rst)
        err_overrun |=> !err_overrun);

    // R6: overrun keeps the held word
    a_r6_overrun_keeps: assert property (@(posedge clk) disable iff (rst)
        err_overrun |-> out_valid && $stable(out_data));

    // R7: framing strobe lasts one cycle
    a_r7_frame_single: assert property (@(posedge clk) disable iff (rst)
        err_frame |=> !err_frame);

    // R7: a bad frame presents no word
    a_r7_frame_no_word: assert property (@(posedge clk) disable iff (rst)
        err_frame |-> !$rose(out_valid));

    // R9: strobes coincide with the end of a frame
    a_r9_strobe_at_end: assert property (@(posedge clk) disable iff (rst)
        err_overrun || err_frame |-> $fell(busy));

    // R9: the two strobes never coincide
    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(err_overrun && err_frame));

endmodule

bind serial_rx_stream srx_checker #(.W(DATA_WIDTH)) u_srx_checker (
    .clk         (clk),
    .rst         (rst),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .busy        (busy),
    .err_overrun (err_overrun),
    .err_frame   (err_frame)
);

// File: tb/test_serial_rx_stream.sv
`timescale 1ns/1ps
module test_serial_rx_stream;

    localparam int DW = 8;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx  = 1'b1;
    logic [PW-1:0] div = PW'(1);
    logic          rdy = 1'b1;
    logic [DW-1:0] data;
    logic          valid;
    logic          busy;
    logic          ovr;
    logic          ferr;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int rcv_cnt  = 0;
    int ovr_cnt  = 0;
    int fe_cnt   = 0;
    int rise_cyc = 0;
    int c0       = 0;
    logic [DW-1:0] rcv_data = '0;
    logic          prev_valid = 1'b0;

    always #4 clk = ~clk;

    serial_rx_stream #(.DATA_WIDTH(DW), .PRESCALE_W(PW)) i_serial_rx_stream (
        .clk         (clk),
        .rst         (rst),
        .rx_serial   (rx),
        .baud_div    (div),
        .out_data    (data),
        .out_valid   (valid),
        .out_ready   (rdy),
        .busy        (busy),
        .err_overrun (ovr),
        .err_frame   (ferr)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (valid && rdy) begin
                rcv_cnt  <= rcv_cnt + 1;
                rcv_data <= data;
            end
            if (valid && !prev_valid) rise_cyc <= cyc;
            if (ovr)  ovr_cnt <= ovr_cnt + 1;
            if (ferr) fe_cnt  <= fe_cnt + 1;
        end
        prev_valid <= valid;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [DW-1:0] d, input logic stop, input int p);
        int bl;
        bl = (p == 0) ? 8 : p * 8;
        @(posedge clk); #1 rx = 1'b0; c0 = cyc;
        repeat (bl) @(posedge clk);
        for (int i = 0; i < DW; i++) begin
            #1 rx = d[i];
            repeat (bl) @(posedge clk);
        end
        #1 rx = stop;
        repeat (bl) @(posedge clk);
        #1 rx = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic settle();
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int base;
        int eb;
        logic [DW-1:0] word;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1: outputs idle under reset
        check(!valid && !busy && !ovr && !ferr, "R1 reset", int'({valid, busy, ovr, ferr}), 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(!valid && !busy && !ovr && !ferr, "R1 after reset", int'({valid, busy, ovr, ferr}), 0);

        // R2: every word value at divider 1
        rdy = 1'b1; div = PW'(1);
        for (int v = 0; v < 256; v++) begin
            base = rcv_cnt;
            send_frame(DW'(v), 1'b1, 1);
            settle();
            check(rcv_cnt == base + 1 && rcv_data == DW'(v), "R2 word sweep", int'(rcv_data), v);
        end

        // R3: slower divider over a stride of values, with exact latency
        div = PW'(3);
        for (int v = 0; v < 256; v += 17) begin
            base = rcv_cnt;
            send_frame(DW'(v), 1'b1, 3);
            settle();
            check(rcv_cnt == base + 1 && rcv_data == DW'(v), "R3 divider 3", int'(rcv_data), v);
            check(rise_cyc - c0 == 3 + 4*3 + 8*3*(DW+1), "R3 latency p3", rise_cyc - c0, 3 + 12 + 24*(DW+1));
        end
        div = PW'(2);
        send_frame(8'hC3, 1'b1, 2);
        settle();
        check(rise_cyc - c0 == 3 + 8 + 16*(DW+1), "R3 latency p2", rise_cyc - c0, 3 + 8 + 16*(DW+1));
        // R3: divider 0 behaves as 1
        div = '0;
        base = rcv_cnt;
        send_frame(8'h96, 1'b1, 0);
        settle();
        check(rcv_cnt == base + 1 && rcv_data == 8'h96, "R3 divider zero", int'(rcv_data), 'h96);
        check(rise_cyc - c0 == 3 + 4 + 8*(DW+1), "R3 latency p0", rise_cyc - c0, 3 + 4 + 8*(DW+1));

        // R4/R6: stall then overrun
        div = PW'(1);
        @(posedge clk); #1 rdy = 1'b0;
        base = rcv_cnt;
        eb = ovr_cnt;
        send_frame(8'hA5, 1'b1, 1);
        settle();
        check(valid && data == 8'hA5, "R4 word held", int'(data), 'hA5);
        send_frame(8'h3C, 1'b1, 1);
        settle();
        check(ovr_cnt == eb + 1, "R6 overrun strobe", ovr_cnt - eb, 1);
        check(valid && data == 8'hA5, "R6 old word kept", int'(data), 'hA5);
        // R5: drain with one handshake
        @(posedge clk); #1 rdy = 1'b1;
        settle();
        check(rcv_cnt == base + 1 && rcv_data == 8'hA5, "R5 single transfer", rcv_cnt - base, 1);
        check(!valid, "R5 valid cleared", int'(valid), 0);

        // R10: handshake in the stop-sample cycle
        @(posedge clk); #1 rdy = 1'b0;
        send_frame(8'h11, 1'b1, 1);
        settle();
        base = rcv_cnt;
        eb = ovr_cnt;
        fork
            send_frame(8'hE7, 1'b1, 1);
            begin
                @(posedge clk);
                repeat (2 + 76) @(posedge clk);
                #1 rdy = 1'b1;
                @(posedge clk);
                #1 rdy = 1'b0;
            end
        join
        settle();
        check(ovr_cnt == eb, "R10 no overrun", ovr_cnt - eb, 0);
        check(rcv_cnt == base + 1 && rcv_data == 8'h11, "R10 old word taken", int'(rcv_data), 'h11);
        check(valid && data == 8'hE7, "R10 new word loaded", int'(data), 'hE7);
        @(posedge clk); #1 rdy = 1'b1;
        settle();

        // R7: bad stop bit then recovery
        base = rcv_cnt;
        eb = fe_cnt;
        send_frame(8'h5A, 1'b0, 1);
        settle();
        check(fe_cnt == eb + 1, "R7 frame strobe", fe_cnt - eb, 1);
        check(rcv_cnt == base && !valid, "R7 word dropped", rcv_cnt - base, 0);
        send_frame(8'h81, 1'b1, 1);
        settle();
        check(rcv_cnt == base + 1 && rcv_data == 8'h81, "R7 recovery", int'(rcv_data), 'h81);

        // R8/R9: short glitch is rejected
        div = PW'(4);
        base = rcv_cnt;
        eb = fe_cnt + ovr_cnt;
        @(posedge clk); #1 rx = 1'b0;
        repeat (3) @(posedge clk);
        #1 rx = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy, "R9 busy during start", int'(busy), 1);
        repeat (100) @(posedge clk);
        @(negedge clk);
        check(!busy, "R8 back to idle", int'(busy), 0);
        check(rcv_cnt == base && !valid, "R8 no word", rcv_cnt - base, 0);
        check(fe_cnt + ovr_cnt == eb, "R8 no strobe", fe_cnt + ovr_cnt - eb, 0);
        // R9: busy low after a completed frame
        send_frame(8'h42, 1'b1, 4);
        settle();
        check(!busy && rcv_data == 8'h42, "R9 idle after frame", int'(busy), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule